// File: doc/BRIEF.md
# Middle-Level MESI Line Coherence Controller

This block holds the coherence state of every line tracked by a private middle-level cache. That cache sits between a smaller inner cache above it and a shared, banked directory cache below it. An event classifier in front of the block reads the state of the addressed line from `line_state`. It then presents one classified event per cycle: a request from the inner cache, a response from the inner cache, a request from the directory, or a response from the directory. For each event the block computes the next state of that line and raises a set of one-cycle action strobes. The strobes tell the surrounding datapath what to issue, what to forward, and which input queue to pop, stall or wake.

The stable states record two things: whether this level holds the line, and whether the inner cache holds a copy too. The states with a `U` suffix mean the inner cache also holds the line. The states with an `O` suffix mean only this level holds it. When the inner copy has to be withdrawn, the block sends an invalidate upward. It then sits in a drain state until the inner cache answers. Ack counting and transport are handled outside the block, so an arriving response is already classified as, for example, the last ack or data with no acks outstanding.

Top module: `mlc_line_ctrl`

## Requirements
- R1: State codes are I=0, SU=1, SO=2, EU=3, EO=4, MU=5, MO=6, RD_WAIT=7, EX_WAIT=8, UPG_WAIT=9, RD_WAIT_INV=10, WB_WAIT=11, WB_SINK=12, SU_DRAIN=13, EU_DRAIN=14, MU_DRAIN=15, MO_DRAIN=16, UPG_DRAIN=17. No other value ever appears on `line_state`.
- R2: Event codes are LOAD=0, STORE=1, REPL=2, UP_WB=3, UP_ACK=4, UP_DIRTY=5, UP_INV=6, INV=7, FWD_EX=8, FWD_RD=9, DATA=10, DATA_EXCL=11, DATA_PEER=12, DATA_LAST=13, ACK=14, ACK_LAST=15, WB_ACK=16. Codes 17 to 31 are illegal in every state.
- R3: Reset puts every line in I and clears all strobes.
  - `line_state` combinationally shows the state of the line selected by `ev_line`.
  - An accepted event updates that state at the clock edge, and its strobes are high for exactly the following cycle.
  - A cycle without `ev_valid` produces no strobes.
- R4: In I:
  - LOAD raises `trk_alloc`, `rd_req` and `pop_up`, and moves to RD_WAIT.
  - STORE raises `trk_alloc`, `ex_req` and `pop_up`, and moves to EX_WAIT.
  - INV raises `ack_to_req` and `pop_dnreq`, and stays in I.
- R5: In SU or SO:
  - LOAD raises `up_data` and `pop_up`, and moves to SU.
  - STORE raises `trk_alloc`, `upg_req` and `pop_up`, and moves to UPG_WAIT.
- R6: Loads and stores when only this level holds the line, and writebacks from the inner cache:
  - In EO, LOAD moves to EU. In MO, LOAD moves to MU. Each raises `up_xdata` and `pop_up`.
  - STORE in EO or MO moves to MU, raising `up_xdata` and `pop_up`.
  - UP_WB in EU or MU moves to MO and raises `pop_up`.
- R7: Replacement and writeback:
  - REPL in SO raises `trk_free` and moves to I.
  - REPL in EO or MO raises `trk_alloc`, `wb_req` and `trk_free`, and moves to WB_WAIT.
  - In WB_WAIT or WB_SINK, WB_ACK raises `pop_resp`, `wake` and `trk_free`, and moves to I.
  - In WB_WAIT:
    - INV raises `data_to_dir`.
    - FWD_EX raises `data_to_req`.
    - FWD_RD raises both `data_to_req` and `data_to_dir`.
    - Each of these raises `pop_dnreq` and moves to WB_SINK.
- R8: Directory requests when only this level holds the line:
  - FWD_EX in EO or MO raises `data_to_req`, `trk_free` and `pop_dnreq`, and moves to I.
  - FWD_RD in EO or MO raises `data_to_req`, `data_to_dir` and `pop_dnreq`, and moves to SO.
  - INV in MO raises `data_to_dir`. INV in EO or SO raises `ack_to_req` instead. In both cases `trk_free` and `pop_dnreq` are raised and the line moves to I.
- R9: Read misses:
  - INV in RD_WAIT or RD_WAIT_INV raises `ack_to_req` and `pop_dnreq`, and moves to RD_WAIT_INV.
  - DATA_LAST or DATA_PEER in RD_WAIT raises `up_data` and moves to SU.
  - In RD_WAIT_INV the same events raise `up_stale` and move to I.
  - DATA_PEER additionally raises `unblk`.
  - DATA_EXCL in RD_WAIT or RD_WAIT_INV raises `up_xdata` and `ex_unblk`, and moves to EU.
  - Every one of these data events raises `pop_resp`, `wake` and `trk_free`.
- R10: Exclusive and upgrade misses:
  - INV in EX_WAIT or UPG_WAIT raises `ack_to_req` and `pop_dnreq`, and moves to EX_WAIT.
  - DATA in EX_WAIT raises `pop_resp` and moves to UPG_WAIT.
  - ACK in UPG_WAIT raises `pop_resp` and stays in UPG_WAIT.
  - DATA_LAST in EX_WAIT or UPG_WAIT, and ACK_LAST in UPG_WAIT, raise `up_xdata`, `ex_unblk`, `pop_resp`, `wake` and `trk_free`, and move to MU.
- R11: Withdrawing the inner copy:
  - UP_INV in SU, EU, MU, MO or UPG_WAIT raises `up_inv` and moves to SU_DRAIN, EU_DRAIN, MU_DRAIN, MO_DRAIN or UPG_DRAIN respectively.
  - UP_ACK raises `pop_up` and moves SU_DRAIN to SO, EU_DRAIN to EO, MU_DRAIN and MO_DRAIN to MO, and UPG_DRAIN to EX_WAIT.
  - UP_DIRTY in EU_DRAIN or MU_DRAIN raises `pop_up` and moves to MO.
- R12: Stalls:
  - LOAD, STORE or REPL in any state from 7 to 17 raises only `stall_up` and leaves the state unchanged.
  - INV, FWD_EX or FWD_RD in any drain state (13 to 17) raises only `stall_dnreq` and leaves the state unchanged.
- R13: Any event not listed above for the current state raises only `ev_err` and leaves the state unchanged.
- R14: An event changes only the line selected by `ev_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A classified event is presented this cycle |
| ev_line | input | LINE_W | Index of the tracked line the event applies to |
| ev_kind | input | 5 | Event code (R2) |
| line_state | output | 5 | Current state of line `ev_line` (R1) |
| rd_req | output | 1 | Issue a shared read request downward |
| ex_req | output | 1 | Issue an exclusive request downward |
| upg_req | output | 1 | Issue an upgrade request downward |
| wb_req | output | 1 | Issue a writeback downward |
| data_to_req | output | 1 | Send line data to the forwarded requester |
| data_to_dir | output | 1 | Send line data to the directory |
| ack_to_req | output | 1 | Send an invalidate ack (count 1) to the requester |
| unblk | output | 1 | Send an unblock to the directory |
| ex_unblk | output | 1 | Send an exclusive unblock to the directory |
| up_data | output | 1 | Return shared data to the inner cache |
| up_xdata | output | 1 | Return exclusive data to the inner cache |
| up_stale | output | 1 | Return stale, use-once data to the inner cache |
| up_inv | output | 1 | Invalidate the inner cache's copy |
| pop_up | output | 1 | Pop the queue from the inner cache |
| pop_dnreq | output | 1 | Pop the request queue from the directory |
| pop_resp | output | 1 | Pop the response queue from the directory |
| stall_up | output | 1 | Park the inner-cache request on this line |
| stall_dnreq | output | 1 | Park the directory request on this line |
| wake | output | 1 | Wake requests parked on this line |
| trk_alloc | output | 1 | Allocate the line or its tracking entry |
| trk_free | output | 1 | Free the line or its tracking entry |
| ev_err | output | 1 | The event is illegal for the current state |

## Verification
The bench builds the block with NUM_LINES=4 and LINE_W=2. With that configuration, a full sweep is cheap.

- Every one of the 18 states is reached from reset through a short event path.
- Every one of the 32 event codes, legal or not, is then applied in that state.
- The resulting next state and all 22 strobes are compared with the values derived from the requirements.

The small line index lets the bench drive a path on one line and confirm that a neighbouring line has stayed in I.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    localparam int ST_W  = 5;
    localparam int EV_W  = 5;
    localparam int NUM_ST = 18;

    typedef enum logic [ST_W-1:0] {
        ST_I           = 5'd0,
        ST_SU          = 5'd1,
        ST_SO          = 5'd2,
        ST_EU          = 5'd3,
        ST_EO          = 5'd4,
        ST_MU          = 5'd5,
        ST_MO          = 5'd6,
        ST_RD_WAIT     = 5'd7,
        ST_EX_WAIT     = 5'd8,
        ST_UPG_WAIT    = 5'd9,
        ST_RD_WAIT_INV = 5'd10,
        ST_WB_WAIT     = 5'd11,
        ST_WB_SINK     = 5'd12,
        ST_SU_DRAIN    = 5'd13,
        ST_EU_DRAIN    = 5'd14,
        ST_MU_DRAIN    = 5'd15,
        ST_MO_DRAIN    = 5'd16,
        ST_UPG_DRAIN   = 5'd17
    } lstate_t;

    typedef enum logic [EV_W-1:0] {
        EV_LOAD      = 5'd0,
        EV_STORE     = 5'd1,
        EV_REPL      = 5'd2,
        EV_UP_WB     = 5'd3,
        EV_UP_ACK    = 5'd4,
        EV_UP_DIRTY  = 5'd5,
        EV_UP_INV    = 5'd6,
        EV_INV       = 5'd7,
        EV_FWD_EX    = 5'd8,
        EV_FWD_RD    = 5'd9,
        EV_DATA      = 5'd10,
        EV_DATA_EXCL = 5'd11,
        EV_DATA_PEER = 5'd12,
        EV_DATA_LAST = 5'd13,
        EV_ACK       = 5'd14,
        EV_ACK_LAST  = 5'd15,
        EV_WB_ACK    = 5'd16
    } levent_t;

    typedef struct packed {
        logic rd_req;
        logic ex_req;
        logic upg_req;
        logic wb_req;
        logic data_to_req;
        logic data_to_dir;
        logic ack_to_req;
        logic unblk;
        logic ex_unblk;
        logic up_data;
        logic up_xdata;
        logic up_stale;
        logic up_inv;
        logic pop_up;
        logic pop_dnreq;
        logic pop_resp;
        logic stall_up;
        logic stall_dnreq;
        logic wake;
        logic trk_alloc;
        logic trk_free;
        logic err;
    } strobe_t;

    // Any miss, writeback or drain in flight: inner requests must wait.
    function automatic logic is_transient(input lstate_t s);
        return (s >= ST_RD_WAIT);
    endfunction

    // Inner copy being withdrawn: directory requests must wait.
    function automatic logic is_drain(input lstate_t s);
        return (s >= ST_SU_DRAIN);
    endfunction

endpackage

// File: rtl/mlc_state_bank.sv
module mlc_state_bank
    import mlc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [LINE_W-1:0] idx,
    input  lstate_t           wval,
    output lstate_t           rval
);

    lstate_t st [NUM_LINES];

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst)
                    st[g] <= ST_I;
                else if (we && idx == LINE_W'(g))
                    st[g] <= wval;
            end
        end
    endgenerate

    assign rval = st[idx];

endmodule

// File: rtl/mlc_step.sv
module mlc_step
    import mlc_pkg::*;
(
    input  lstate_t          cur,
    input  logic [EV_W-1:0]  kind,
    output lstate_t          nxt,
    output strobe_t          act
);

    levent_t ev;
    logic    ok;
    logic    up_req_ev;
    logic    dn_req_ev;

    always_comb begin
        ev        = levent_t'(kind);
        nxt       = cur;
        act       = '0;
        ok        = 1'b1;
        up_req_ev = (ev == EV_LOAD) || (ev == EV_STORE) || (ev == EV_REPL);
        dn_req_ev = (ev == EV_INV) || (ev == EV_FWD_EX) || (ev == EV_FWD_RD);

        if (is_transient(cur) && up_req_ev) begin
            act.stall_up = 1'b1;
        end else if (is_drain(cur) && dn_req_ev) begin
            act.stall_dnreq = 1'b1;
        end else begin
            case (cur)
                ST_I: case (ev)
                    EV_LOAD:  begin nxt = ST_RD_WAIT; act.trk_alloc = 1'b1; act.rd_req = 1'b1; act.pop_up = 1'b1; end
                    EV_STORE: begin nxt = ST_EX_WAIT; act.trk_alloc = 1'b1; act.ex_req = 1'b1; act.pop_up = 1'b1; end
                    EV_INV:   begin act.ack_to_req = 1'b1; act.pop_dnreq = 1'b1; end
                    default:  ok = 1'b0;
                endcase
                ST_SU, ST_SO: case (ev)
                    EV_LOAD:   begin nxt = ST_SU; act.up_data = 1'b1; act.pop_up = 1'b1; end
                    EV_STORE:  begin nxt = ST_UPG_WAIT; act.trk_alloc = 1'b1; act.upg_req = 1'b1; act.pop_up = 1'b1; end
                    EV_UP_INV: if (cur == ST_SU) begin nxt = ST_SU_DRAIN; act.up_inv = 1'b1; end else ok = 1'b0;
                    EV_REPL:   if (cur == ST_SO) begin nxt = ST_I; act.trk_free = 1'b1; end else ok = 1'b0;
                    EV_INV:    if (cur == ST_SO) begin nxt = ST_I; act.ack_to_req = 1'b1; act.trk_free = 1'b1; act.pop_dnreq = 1'b1; end else ok = 1'b0;
                    default:   ok = 1'b0;
                endcase
                ST_EU, ST_MU: case (ev)
                    EV_UP_WB:  begin nxt = ST_MO; act.pop_up = 1'b1; end
                    EV_UP_INV: begin nxt = (cur == ST_EU) ? ST_EU_DRAIN : ST_MU_DRAIN; act.up_inv = 1'b1; end
                    default:   ok = 1'b0;
                endcase
                ST_EO, ST_MO: case (ev)
                    EV_LOAD:   begin nxt = (cur == ST_EO) ? ST_EU : ST_MU; act.up_xdata = 1'b1; act.pop_up = 1'b1; end
                    EV_STORE:  begin nxt = ST_MU; act.up_xdata = 1'b1; act.pop_up = 1'b1; end
                    EV_REPL:   begin nxt = ST_WB_WAIT; act.trk_alloc = 1'b1; act.wb_req = 1'b1; act.trk_free = 1'b1; end
                    EV_FWD_EX: begin nxt = ST_I; act.data_to_req = 1'b1; act.trk_free = 1'b1; act.pop_dnreq = 1'b1; end
                    EV_FWD_RD: begin nxt = ST_SO; act.data_to_req = 1'b1; act.data_to_dir = 1'b1; act.pop_dnreq = 1'b1; end
                    EV_INV:    begin
                        nxt = ST_I; act.trk_free = 1'b1; act.pop_dnreq = 1'b1;
                        if (cur == ST_MO) act.data_to_dir = 1'b1; else act.ack_to_req = 1'b1;
                    end
                    EV_UP_INV: if (cur == ST_MO) begin nxt = ST_MO_DRAIN; act.up_inv = 1'b1; end else ok = 1'b0;
                    default:   ok = 1'b0;
                endcase
                ST_WB_WAIT, ST_WB_SINK: case (ev)
                    EV_WB_ACK: begin nxt = ST_I; act.pop_resp = 1'b1; act.wake = 1'b1; act.trk_free = 1'b1; end
                    EV_INV, EV_FWD_EX, EV_FWD_RD:
                        if (cur == ST_WB_WAIT) begin
                            nxt = ST_WB_SINK; act.pop_dnreq = 1'b1;
                            act.data_to_dir = (ev != EV_FWD_EX);
                            act.data_to_req = (ev != EV_INV);
                        end else ok = 1'b0;
                    default: ok = 1'b0;
                endcase
                ST_RD_WAIT, ST_RD_WAIT_INV: case (ev)
                    EV_INV: begin nxt = ST_RD_WAIT_INV; act.ack_to_req = 1'b1; act.pop_dnreq = 1'b1; end
                    EV_DATA_LAST, EV_DATA_PEER: begin
                        act.pop_resp = 1'b1; act.wake = 1'b1; act.trk_free = 1'b1;
                        act.unblk = (ev == EV_DATA_PEER);
                        if (cur == ST_RD_WAIT) begin nxt = ST_SU; act.up_data = 1'b1; end
                        else begin nxt = ST_I; act.up_stale = 1'b1; end
                    end
                    EV_DATA_EXCL: begin
                        nxt = ST_EU; act.up_xdata = 1'b1; act.ex_unblk = 1'b1;
                        act.pop_resp = 1'b1; act.wake = 1'b1; act.trk_free = 1'b1;
                    end
                    default: ok = 1'b0;
                endcase
                ST_EX_WAIT, ST_UPG_WAIT: case (ev)
                    EV_INV:  begin nxt = ST_EX_WAIT; act.ack_to_req = 1'b1; act.pop_dnreq = 1'b1; end
                    EV_DATA: if (cur == ST_EX_WAIT) begin nxt = ST_UPG_WAIT; act.pop_resp = 1'b1; end else ok = 1'b0;
                    EV_ACK:  if (cur == ST_UPG_WAIT) act.pop_resp = 1'b1; else ok = 1'b0;
                    EV_UP_INV: if (cur == ST_UPG_WAIT) begin nxt = ST_UPG_DRAIN; act.up_inv = 1'b1; end else ok = 1'b0;
                    EV_DATA_LAST, EV_ACK_LAST:
                        if (ev == EV_DATA_LAST || cur == ST_UPG_WAIT) begin
                            nxt = ST_MU; act.up_xdata = 1'b1; act.ex_unblk = 1'b1;
                            act.pop_resp = 1'b1; act.wake = 1'b1; act.trk_free = 1'b1;
                        end else ok = 1'b0;
                    default: ok = 1'b0;
                endcase
                ST_SU_DRAIN, ST_EU_DRAIN, ST_MU_DRAIN, ST_MO_DRAIN, ST_UPG_DRAIN: case (ev)
                    EV_UP_ACK: begin
                        act.pop_up = 1'b1;
                        case (cur)
                            ST_SU_DRAIN: nxt = ST_SO;
                            ST_EU_DRAIN: nxt = ST_EO;
                            ST_UPG_DRAIN: nxt = ST_EX_WAIT;
                            default:     nxt = ST_MO;
                        endcase
                    end
                    EV_UP_DIRTY:
                        if (cur == ST_EU_DRAIN || cur == ST_MU_DRAIN) begin
                            nxt = ST_MO; act.pop_up = 1'b1;
                        end else ok = 1'b0;
                    default: ok = 1'b0;
                endcase
                default: ok = 1'b0;
            endcase
        end

        if (!ok) begin
            act     = '0;
            act.err = 1'b1;
            nxt     = cur;
        end
    end

endmodule

// File: rtl/mlc_strobe_reg.sv
module mlc_strobe_reg
    import mlc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid,
    input  strobe_t d,
    output strobe_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (valid)
            q <= d;
        else
            q <= '0;
    end

endmodule

// File: rtl/mlc_line_ctrl.sv
module mlc_line_ctrl
    import mlc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [LINE_W-1:0] ev_line,
    input  logic [EV_W-1:0]   ev_kind,
    output logic [ST_W-1:0]   line_state,
    output logic              rd_req,
    output logic              ex_req,
    output logic              upg_req,
    output logic              wb_req,
    output logic              data_to_req,
    output logic              data_to_dir,
    output logic              ack_to_req,
    output logic              unblk,
    output logic              ex_unblk,
    output logic              up_data,
    output logic              up_xdata,
    output logic              up_stale,
    output logic              up_inv,
    output logic              pop_up,
    output logic              pop_dnreq,
    output logic              pop_resp,
    output logic              stall_up,
    output logic              stall_dnreq,
    output logic              wake,
    output logic              trk_alloc,
    output logic              trk_free,
    output logic              ev_err
);

    lstate_t cur_st;
    lstate_t nxt_st;
    strobe_t act_d;
    strobe_t act_q;

    mlc_state_bank #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (ev_valid),
        .idx  (ev_line),
        .wval (nxt_st),
        .rval (cur_st)
    );

    mlc_step u_step (
        .cur  (cur_st),
        .kind (ev_kind),
        .nxt  (nxt_st),
        .act  (act_d)
    );

    mlc_strobe_reg u_sreg (
        .clk   (clk),
        .rst   (rst),
        .valid (ev_valid),
        .d     (act_d),
        .q     (act_q)
    );

    assign line_state  = cur_st;
    assign rd_req      = act_q.rd_req;
    assign ex_req      = act_q.ex_req;
    assign upg_req     = act_q.upg_req;
    assign wb_req      = act_q.wb_req;
    assign data_to_req = act_q.data_to_req;
    assign data_to_dir = act_q.data_to_dir;
    assign ack_to_req  = act_q.ack_to_req;
    assign unblk       = act_q.unblk;
    assign ex_unblk    = act_q.ex_unblk;
    assign up_data     = act_q.up_data;
    assign up_xdata    = act_q.up_xdata;
    assign up_stale    = act_q.up_stale;
    assign up_inv      = act_q.up_inv;
    assign pop_up      = act_q.pop_up;
    assign pop_dnreq   = act_q.pop_dnreq;
    assign pop_resp    = act_q.pop_resp;
    assign stall_up    = act_q.stall_up;
    assign stall_dnreq = act_q.stall_dnreq;
    assign wake        = act_q.wake;
    assign trk_alloc   = act_q.trk_alloc;
    assign trk_free    = act_q.trk_free;
    assign ev_err      = act_q.err;

endmodule

// File: rtl/mlc_line_chk.sv
module mlc_line_chk #(
    parameter int LINE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic [LINE_W-1:0] ev_line,
    input logic [4:0]        line_state,
    input logic [3:0]        issue,
    input logic [3:0]        upward,
    input logic [20:0]       others,
    input logic              stall_up,
    input logic              stall_dnreq,
    input logic              pop_up,
    input logic              pop_dnreq,
    input logic              pop_resp,
    input logic              ev_err
);

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        line_state <= 5'd17) else $error("state code out of range"); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> (others == '0) && !ev_err) else $error("strobe without event"); // R3

    AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (rst)
        $countones(issue) <= 1) else $error("two downward requests at once"); // R4

    AST_UP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upward)) else $error("two upward messages at once"); // R9

    AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (rst)
        (stall_up || stall_dnreq) |-> !(pop_up || pop_dnreq || pop_resp)) else $error("stall with pop"); // R12

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(ev_valid) && (stall_up || stall_dnreq || ev_err) && ev_line == $past(ev_line))
        |-> line_state == $past(line_state)) else $error("state moved on stall or error"); // R12

    AST_ERR_ALONE: assert property (@(posedge clk) disable iff (rst)
        ev_err |-> (others == '0)) else $error("error with other strobes"); // R13

endmodule

bind mlc_line_ctrl mlc_line_chk #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_valid    (ev_valid),
    .ev_line     (ev_line),
    .line_state  (line_state),
    .issue       ({rd_req, ex_req, upg_req, wb_req}),
    .upward      ({up_data, up_xdata, up_stale, up_inv}),
    .others      ({rd_req, ex_req, upg_req, wb_req, data_to_req, data_to_dir, ack_to_req,
                   unblk, ex_unblk, up_data, up_xdata, up_stale, up_inv, pop_up, pop_dnreq,
                   pop_resp, stall_up, stall_dnreq, wake, trk_alloc, trk_free}),
    .stall_up    (stall_up),
    .stall_dnreq (stall_dnreq),
    .pop_up      (pop_up),
    .pop_dnreq   (pop_dnreq),
    .pop_resp    (pop_resp),
    .ev_err      (ev_err)
);

// File: tb/sim_mlc_line_ctrl.sv
module sim_mlc_line_ctrl;

    localparam int NL = 4;
    localparam int LW = 2;

    // state codes (R1)
    localparam int S_I = 0, S_SU = 1, S_SO = 2, S_EU = 3, S_EO = 4, S_MU = 5, S_MO = 6;
    localparam int S_RW = 7, S_XW = 8, S_UW = 9, S_RWI = 10, S_WBW = 11, S_SNK = 12;
    localparam int S_SUD = 13, S_EUD = 14, S_MUD = 15, S_MOD = 16, S_UWD = 17;
    // event codes (R2)
    localparam int E_LD = 0, E_ST = 1, E_RP = 2, E_UWB = 3, E_UACK = 4, E_UDRT = 5, E_UINV = 6;
    localparam int E_INV = 7, E_FX = 8, E_FR = 9, E_DAT = 10, E_DEX = 11, E_DPR = 12;
    localparam int E_DLS = 13, E_ACK = 14, E_ACL = 15, E_WBA = 16;
    // bench bit positions of the strobe vector
    localparam int B_RD = 0, B_EX = 1, B_UPG = 2, B_WB = 3, B_DREQ = 4, B_DDIR = 5, B_ACK = 6;
    localparam int B_UNB = 7, B_XUNB = 8, B_UDAT = 9, B_UXD = 10, B_UST = 11, B_UINV = 12;
    localparam int B_PUP = 13, B_PDN = 14, B_PRSP = 15, B_SUP = 16, B_SDN = 17, B_WAKE = 18;
    localparam int B_ALLOC = 19, B_FREE = 20, B_ERR = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ev_valid = 1'b0;
    logic [LW-1:0] ev_line = '0;
    logic [4:0]    ev_kind = '0;
    logic [4:0]    line_state;
    logic rd_req, ex_req, upg_req, wb_req, data_to_req, data_to_dir, ack_to_req;
    logic unblk, ex_unblk, up_data, up_xdata, up_stale, up_inv, pop_up, pop_dnreq;
    logic pop_resp, stall_up, stall_dnreq, wake, trk_alloc, trk_free, ev_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mlc_line_ctrl #(.NUM_LINES(NL), .LINE_W(LW)) u0 (.*);

    function automatic logic [21:0] strobes();
        logic [21:0] v;
        v = '0;
        v[B_RD] = rd_req;   v[B_EX] = ex_req;     v[B_UPG] = upg_req;   v[B_WB] = wb_req;
        v[B_DREQ] = data_to_req; v[B_DDIR] = data_to_dir; v[B_ACK] = ack_to_req;
        v[B_UNB] = unblk;   v[B_XUNB] = ex_unblk; v[B_UDAT] = up_data;  v[B_UXD] = up_xdata;
        v[B_UST] = up_stale; v[B_UINV] = up_inv;  v[B_PUP] = pop_up;    v[B_PDN] = pop_dnreq;
        v[B_PRSP] = pop_resp; v[B_SUP] = stall_up; v[B_SDN] = stall_dnreq; v[B_WAKE] = wake;
        v[B_ALLOC] = trk_alloc; v[B_FREE] = trk_free; v[B_ERR] = ev_err;
        return v;
    endfunction

    function automatic logic [21:0] bt(input int n);
        return 22'(1) << n;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected next state and strobes, written from the requirement text.
    task automatic expect_step(input int s, input int e, output int ns, output logic [21:0] m);
        logic ok;
        ok = 1'b1; ns = s; m = '0;
        if (s >= S_RW && e <= E_RP) m = bt(B_SUP);                          // R12
        else if (s >= S_SUD && (e == E_INV || e == E_FX || e == E_FR)) m = bt(B_SDN); // R12
        else if (s == S_I) begin                                           // R4
            if (e == E_LD)      begin ns = S_RW; m = bt(B_ALLOC) | bt(B_RD) | bt(B_PUP); end
            else if (e == E_ST) begin ns = S_XW; m = bt(B_ALLOC) | bt(B_EX) | bt(B_PUP); end
            else if (e == E_INV) m = bt(B_ACK) | bt(B_PDN);
            else ok = 1'b0;
        end else if (s == S_SU || s == S_SO) begin                         // R5, R7, R8, R11
            if (e == E_LD)      begin ns = S_SU; m = bt(B_UDAT) | bt(B_PUP); end
            else if (e == E_ST) begin ns = S_UW; m = bt(B_ALLOC) | bt(B_UPG) | bt(B_PUP); end
            else if (s == S_SU && e == E_UINV) begin ns = S_SUD; m = bt(B_UINV); end
            else if (s == S_SO && e == E_RP)   begin ns = S_I; m = bt(B_FREE); end
            else if (s == S_SO && e == E_INV)  begin ns = S_I; m = bt(B_ACK) | bt(B_FREE) | bt(B_PDN); end
            else ok = 1'b0;
        end else if (s == S_EU || s == S_MU) begin                         // R6, R11
            if (e == E_UWB)       begin ns = S_MO; m = bt(B_PUP); end
            else if (e == E_UINV) begin ns = (s == S_EU) ? S_EUD : S_MUD; m = bt(B_UINV); end
            else ok = 1'b0;
        end else if (s == S_EO || s == S_MO) begin                         // R6, R7, R8
            if (e == E_LD)      begin ns = (s == S_EO) ? S_EU : S_MU; m = bt(B_UXD) | bt(B_PUP); end
            else if (e == E_ST) begin ns = S_MU; m = bt(B_UXD) | bt(B_PUP); end
            else if (e == E_RP) begin ns = S_WBW; m = bt(B_ALLOC) | bt(B_WB) | bt(B_FREE); end
            else if (e == E_FX) begin ns = S_I; m = bt(B_DREQ) | bt(B_FREE) | bt(B_PDN); end
            else if (e == E_FR) begin ns = S_SO; m = bt(B_DREQ) | bt(B_DDIR) | bt(B_PDN); end
            else if (e == E_INV) begin ns = S_I; m = bt(B_FREE) | bt(B_PDN) | ((s == S_MO) ? bt(B_DDIR) : bt(B_ACK)); end
            else if (s == S_MO && e == E_UINV) begin ns = S_MOD; m = bt(B_UINV); end
            else ok = 1'b0;
        end else if (s == S_WBW || s == S_SNK) begin                       // R7
            if (e == E_WBA) begin ns = S_I; m = bt(B_PRSP) | bt(B_WAKE) | bt(B_FREE); end
            else if (s == S_WBW && e == E_INV) begin ns = S_SNK; m = bt(B_DDIR) | bt(B_PDN); end
            else if (s == S_WBW && e == E_FX)  begin ns = S_SNK; m = bt(B_DREQ) | bt(B_PDN); end
            else if (s == S_WBW && e == E_FR)  begin ns = S_SNK; m = bt(B_DREQ) | bt(B_DDIR) | bt(B_PDN); end
            else ok = 1'b0;
        end else if (s == S_RW || s == S_RWI) begin                        // R9
            if (e == E_INV) begin ns = S_RWI; m = bt(B_ACK) | bt(B_PDN); end
            else if (e == E_DLS || e == E_DPR) begin
                m = bt(B_PRSP) | bt(B_WAKE) | bt(B_FREE) | ((e == E_DPR) ? bt(B_UNB) : '0);
                if (s == S_RW) begin ns = S_SU; m |= bt(B_UDAT); end
                else           begin ns = S_I;  m |= bt(B_UST);  end
            end else if (e == E_DEX) begin
                ns = S_EU; m = bt(B_UXD) | bt(B_XUNB) | bt(B_PRSP) | bt(B_WAKE) | bt(B_FREE);
            end else ok = 1'b0;
        end else if (s == S_XW || s == S_UW) begin                         // R10
            if (e == E_INV) begin ns = S_XW; m = bt(B_ACK) | bt(B_PDN); end
            else if (s == S_XW && e == E_DAT)  begin ns = S_UW; m = bt(B_PRSP); end
            else if (s == S_UW && e == E_ACK)  m = bt(B_PRSP);
            else if (s == S_UW && e == E_UINV) begin ns = S_UWD; m = bt(B_UINV); end
            else if (e == E_DLS || (s == S_UW && e == E_ACL)) begin
                ns = S_MU; m = bt(B_UXD) | bt(B_XUNB) | bt(B_PRSP) | bt(B_WAKE) | bt(B_FREE);
            end else ok = 1'b0;
        end else begin                                                     // R11 drains
            if (e == E_UACK) begin
                m = bt(B_PUP);
                ns = (s == S_SUD) ? S_SO : (s == S_EUD) ? S_EO : (s == S_UWD) ? S_XW : S_MO;
            end else if (e == E_UDRT && (s == S_EUD || s == S_MUD)) begin
                ns = S_MO; m = bt(B_PUP);
            end else ok = 1'b0;
        end
        if (!ok) begin ns = s; m = bt(B_ERR); end                         // R13
    endtask

    function automatic string tag_of(input int s, input int e, input logic [21:0] m);
        if (e > E_WBA) return "R2";
        if (m[B_ERR]) return "R13";
        if (m[B_SUP] || m[B_SDN]) return "R12";
        if ((s == S_EO || s == S_MO || s == S_SO) && (e == E_INV || e == E_FX || e == E_FR)) return "R8";
        if ((s == S_EO || s == S_MO || s == S_SO) && e == E_RP) return "R7";
        if (e == E_UINV || s >= S_SUD) return "R11";
        case (s)
            S_I: return "R4";
            S_SU, S_SO: return "R5";
            S_EU, S_EO, S_MU, S_MO: return "R6";
            S_WBW, S_SNK: return "R7";
            S_RW, S_RWI: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic send(input int e);
        @(negedge clk);
        ev_kind  = 5'(e);
        ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ev_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic goto_state(input int s);
        case (s)
            S_RW:  send(E_LD);
            S_XW:  send(E_ST);
            S_SU:  begin send(E_LD); send(E_DLS); end
            S_SO:  begin send(E_LD); send(E_DLS); send(E_UINV); send(E_UACK); end
            S_EU:  begin send(E_LD); send(E_DEX); end
            S_EO:  begin send(E_LD); send(E_DEX); send(E_UINV); send(E_UACK); end
            S_MU:  begin send(E_ST); send(E_DLS); end
            S_MO:  begin send(E_ST); send(E_DLS); send(E_UWB); end
            S_UW:  begin send(E_LD); send(E_DLS); send(E_ST); end
            S_RWI: begin send(E_LD); send(E_INV); end
            S_WBW: begin send(E_ST); send(E_DLS); send(E_UWB); send(E_RP); end
            S_SNK: begin send(E_ST); send(E_DLS); send(E_UWB); send(E_RP); send(E_INV); end
            S_SUD: begin send(E_LD); send(E_DLS); send(E_UINV); end
            S_EUD: begin send(E_LD); send(E_DEX); send(E_UINV); end
            S_MUD: begin send(E_ST); send(E_DLS); send(E_UINV); end
            S_MOD: begin send(E_ST); send(E_DLS); send(E_UWB); send(E_UINV); end
            S_UWD: begin send(E_LD); send(E_DLS); send(E_ST); send(E_UINV); end
            default: ;
        endcase
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int ns;
        logic [21:0] m;
        do_reset();
        // reset state of every line (R3)
        for (int l = 0; l < NL; l++) begin
            ev_line = LW'(l);
            #1;
            check("R3", "reset state", 32'(line_state), S_I);
        end
        check("R3", "reset strobes", 32'(strobes()), 0);

        for (int s = 0; s < 18; s++) begin
            for (int e = 0; e < 32; e++) begin
                do_reset();
                ev_line = 2'd2;
                goto_state(s);
                check("R1", $sformatf("reach %0d", s), 32'(line_state), 32'(s));
                if (e == 0) begin
                    ev_line = 2'd1;
                    #1;
                    check("R14", "neighbour untouched", 32'(line_state), S_I);
                    ev_line = 2'd2;
                    #1;
                end
                expect_step(s, e, ns, m);
                send(e);
                check(tag_of(s, e, m), $sformatf("strobes s=%0d e=%0d", s, e), 32'(strobes()), 32'(m));
                check(tag_of(s, e, m), $sformatf("next s=%0d e=%0d", s, e), 32'(line_state), 32'(ns));
                if (e == 0) begin
                    @(negedge clk);
                    check("R3", "idle cycle strobes", 32'(strobes()), 0);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule